// File: doc/BRIEF.md
# Pushbutton Power-State Controller

This block sequences a multi-rail supply up and down under control of an active-low pushbutton, a power-hold line driven by the system processor, an undervoltage flag and an external-supply-valid flag. It is a synchronous state machine with four states: off, power-up, on and power-down. All of its timing is counted in a one-millisecond tick enable supplied by a prescaler elsewhere, so the intervals are parameters in ticks.

In the on state a long button press is reported on a status output so that firmware can decide to shut down. Firmware shuts down by dropping the power-hold line. An undervoltage event shuts down at once. Either kind of shutdown drops every regulator enable together. It also pulses a clear to the auxiliary regulator and backlight control registers. It then holds a lockout period during which every input is ignored. After an undervoltage shutdown the block retries on its own, passing through off, once the undervoltage has cleared and an external supply is valid. After any shutdown, a button that is still held counts for nothing until it has been released.

Top module: `pbpwr_ctrl`

## Requirements
- R1: After reset all outputs are low and the state is off. A button held low from reset does not power up: it must first be seen high in the off state.
- R2: In the off state, a low button after a release seen in that state moves the block to power-up on the next clock. Wake goes high and rail enable bit 0 goes high in that cycle.
- R3: In power-up, the rail enables turn on in index order 0, 1, 2. Bit k rises STAGGER_TICKS ticks after bit k-1. A higher-index enable is never high while a lower one is low.
- R4: The block enters the on state one clock after the last rail enable rises. Power-good is high only in the on state, with every rail enabled.
- R5: In the on state, the pushbutton-status output is high once the button has been low for PRESS_TICKS consecutive ticks. It drops combinationally, in the same cycle the button returns high.
- R6: In the on state, power-hold low for HOLD_TICKS consecutive ticks moves the block to power-down on the following clock. Power-hold returning high earlier restarts the count.
- R7: On entry to power-down, all rail enables, wake and power-good fall in the same cycle. The register-clear output is high for exactly that first cycle.
- R8: Power-down lasts LOCK_TICKS ticks plus one clock, then moves to off. Button, power-hold and external-supply inputs have no effect during it.
- R9: A button held low through power-down, or pressed during it, does not power up. A release and a fresh press in the off state does.
- R10: An undervoltage flag in the on state moves the block to power-down on the next clock.
- R11: After an undervoltage shutdown, the block spends one clock in off after the lockout and then enters power-up, provided the undervoltage flag is low and the external supply is valid. Otherwise it waits in off until both hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_ms | input | 1 | One-cycle millisecond tick enable |
| btn_n | input | 1 | Pushbutton, low when pressed |
| hold_i | input | 1 | Processor power-hold, low requests shutdown |
| uvlo_i | input | 1 | Undervoltage flag |
| ext_ok_i | input | 1 | External supply valid |
| pb_stat_o | output | 1 | Long-press status |
| wake_o | output | 1 | Wake, high in power-up and on |
| pgood_o | output | 1 | Power-good, high in on |
| rail_en_o | output | NUM_RAILS | Regulator enables, bit 0 first |
| aux_clr_o | output | 1 | One-cycle clear for auxiliary regulator and backlight registers |

## Verification
The bench sweeps press and hold durations up to and past their limits. A counter that was off by one would assert status or shut down a tick early or late. The bench holds the button and applies external power through the lockout. A design that forgot to disarm the button would then restart straight out of power-down. After an undervoltage shutdown it times the retry to the exact cycle, and also withholds external power. A design that skipped the off state, or that retried without a valid supply, would raise wake at the wrong time. Rail order and spacing are sampled tick by tick during power-up.

// File: rtl/pbpwr_pkg.sv
package pbpwr_pkg;
   typedef enum logic [1:0] {
      ST_OFF  = 2'd0,
      ST_UP   = 2'd1,
      ST_ON   = 2'd2,
      ST_DOWN = 2'd3
   } pwr_state_e;
endpackage

// File: rtl/pbpwr_tick_timer.sv
module pbpwr_tick_timer #(
   parameter int LIMIT = 50
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic run,
   output logic done
);
   localparam int CW = $clog2(LIMIT + 1);
   localparam logic [CW-1:0] LIM_C = CW'(LIMIT);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (!run)
         cnt <= '0;
      else if (tick && (cnt != LIM_C))
         cnt <= cnt + 1'b1;
   end

   assign done = run && (cnt == LIM_C);
endmodule

// File: rtl/pbpwr_rail_seq.sv
module pbpwr_rail_seq #(
   parameter int NR      = 3,
   parameter int STAGGER = 10
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic          run,
   output logic [NR-1:0] rails,
   output logic          last_up
);
   generate
      if (STAGGER == 0) begin : g_flat
         assign rails   = {NR{run}};
         assign last_up = run;
      end else begin : g_step
         localparam int SPAN = (NR - 1) * STAGGER;
         localparam int CW   = $clog2(SPAN + 1);
         localparam logic [CW-1:0] SPAN_C = CW'(SPAN);

         logic [CW-1:0] cnt;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               cnt <= '0;
            else if (!run)
               cnt <= '0;
            else if (tick && (cnt != SPAN_C))
               cnt <= cnt + 1'b1;
         end

         for (genvar k = 0; k < NR; k++) begin : g_rail
            localparam logic [CW-1:0] AT_C = CW'(k * STAGGER);
            assign rails[k] = run && (cnt >= AT_C);
         end

         assign last_up = run && (cnt == SPAN_C);
      end
   endgenerate
endmodule

// File: rtl/pbpwr_fsm.sv
module pbpwr_fsm
   import pbpwr_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       btn_n,
   input  logic       uvlo,
   input  logic       ext_ok,
   input  logic       hold_exp,
   input  logic       lock_exp,
   input  logic       seq_last,
   output pwr_state_e st,
   output logic       aux_clr
);
   pwr_state_e nxt;
   logic       armed;
   logic       retry;

   always_comb begin
      nxt = st;
      unique case (st)
         ST_OFF:  if ((!btn_n && armed) || (retry && !uvlo && ext_ok)) nxt = ST_UP;
         ST_UP:   if (seq_last) nxt = ST_ON;
         ST_ON:   if (uvlo || hold_exp) nxt = ST_DOWN;
         ST_DOWN: if (lock_exp) nxt = ST_OFF;
         default: nxt = ST_OFF;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_OFF;
         aux_clr <= 1'b0;
         armed   <= 1'b0;
         retry   <= 1'b0;
      end else begin
         st      <= nxt;
         aux_clr <= (nxt == ST_DOWN) && (st != ST_DOWN);
         armed   <= (nxt == ST_OFF) && (armed || ((st == ST_OFF) && btn_n));
         if ((st == ST_ON) && (nxt == ST_DOWN))
            retry <= uvlo;
         else if (nxt == ST_UP)
            retry <= 1'b0;
      end
   end
endmodule

// File: rtl/pbpwr_ctrl.sv
module pbpwr_ctrl #(
   parameter int PRESS_TICKS   = 50,
   parameter int HOLD_TICKS    = 50,
   parameter int LOCK_TICKS    = 1000,
   parameter int STAGGER_TICKS = 10,
   parameter int NUM_RAILS     = 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 tick_ms,
   input  logic                 btn_n,
   input  logic                 hold_i,
   input  logic                 uvlo_i,
   input  logic                 ext_ok_i,
   output logic                 pb_stat_o,
   output logic                 wake_o,
   output logic                 pgood_o,
   output logic [NUM_RAILS-1:0] rail_en_o,
   output logic                 aux_clr_o
);
   import pbpwr_pkg::*;

   generate
      if (PRESS_TICKS < 1) begin : g_bad_press
         $error("PRESS_TICKS must be at least 1");
      end
      if (HOLD_TICKS < 1) begin : g_bad_hold
         $error("HOLD_TICKS must be at least 1");
      end
      if (LOCK_TICKS < 1) begin : g_bad_lock
         $error("LOCK_TICKS must be at least 1");
      end
      if (STAGGER_TICKS < 0) begin : g_bad_stagger
         $error("STAGGER_TICKS must not be negative");
      end
      if (NUM_RAILS < 2) begin : g_bad_rails
         $error("NUM_RAILS must be at least 2");
      end
   endgenerate

   pwr_state_e          st;
   logic                press_done;
   logic                hold_exp;
   logic                lock_exp;
   logic                seq_last;
   logic [NUM_RAILS-1:0] seq_rails;

   pbpwr_tick_timer #(.LIMIT(PRESS_TICKS)) u_press (
      .clk  (clk),
      .rst_n(rst_n),
      .tick (tick_ms),
      .run  ((st == ST_ON) && !btn_n),
      .done (press_done)
   );

   pbpwr_tick_timer #(.LIMIT(HOLD_TICKS)) u_hold (
      .clk  (clk),
      .rst_n(rst_n),
      .tick (tick_ms),
      .run  ((st == ST_ON) && !hold_i),
      .done (hold_exp)
   );

   pbpwr_tick_timer #(.LIMIT(LOCK_TICKS)) u_lock (
      .clk  (clk),
      .rst_n(rst_n),
      .tick (tick_ms),
      .run  (st == ST_DOWN),
      .done (lock_exp)
   );

   pbpwr_rail_seq #(.NR(NUM_RAILS), .STAGGER(STAGGER_TICKS)) u_seq (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (tick_ms),
      .run    (st == ST_UP),
      .rails  (seq_rails),
      .last_up(seq_last)
   );

   pbpwr_fsm u_fsm (
      .clk     (clk),
      .rst_n   (rst_n),
      .btn_n   (btn_n),
      .uvlo    (uvlo_i),
      .ext_ok  (ext_ok_i),
      .hold_exp(hold_exp),
      .lock_exp(lock_exp),
      .seq_last(seq_last),
      .st      (st),
      .aux_clr (aux_clr_o)
   );

   assign pb_stat_o = press_done;
   assign wake_o    = (st == ST_UP) || (st == ST_ON);
   assign pgood_o   = (st == ST_ON);
   assign rail_en_o = (st == ST_ON) ? {NUM_RAILS{1'b1}} : seq_rails;
endmodule

// File: rtl/pbpwr_ctrl_chk.sv
module pbpwr_ctrl_chk #(
   parameter int NR = 3
) (
   input logic          clk,
   input logic          rst_n,
   input logic          btn_n,
   input logic          pb_stat_o,
   input logic          wake_o,
   input logic          pgood_o,
   input logic [NR-1:0] rail_en_o,
   input logic          aux_clr_o
);
   AST_RAIL_ORDER: assert property (@(posedge clk) disable iff (!rst_n) ((rail_en_o >> 1) & ~rail_en_o) == '0); // R3
   AST_RAILS_NEED_WAKE: assert property (@(posedge clk) disable iff (!rst_n) (rail_en_o != '0) |-> wake_o); // R2
   AST_PGOOD_FULL: assert property (@(posedge clk) disable iff (!rst_n) pgood_o |-> ((&rail_en_o) && wake_o)); // R4
   AST_PB_RELEASE: assert property (@(posedge clk) disable iff (!rst_n) btn_n |-> !pb_stat_o); // R5
   AST_DROP_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n) $fell(wake_o) |-> ((rail_en_o == '0) && !pgood_o)); // R7
   AST_CLR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) aux_clr_o |=> !aux_clr_o); // R7
   AST_CLR_AT_DROP: assert property (@(posedge clk) disable iff (!rst_n) aux_clr_o |-> $fell(wake_o)); // R7
endmodule

bind pbpwr_ctrl pbpwr_ctrl_chk #(.NR(NUM_RAILS)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .btn_n    (btn_n),
   .pb_stat_o(pb_stat_o),
   .wake_o   (wake_o),
   .pgood_o  (pgood_o),
   .rail_en_o(rail_en_o),
   .aux_clr_o(aux_clr_o)
);

// File: tb/pbpwr_ctrl_tb_top.sv
module pbpwr_ctrl_tb_top;
   localparam int PRESS = 3;
   localparam int HOLD  = 4;
   localparam int LOCK  = 8;
   localparam int STAG  = 2;
   localparam int NR    = 3;
   localparam int TPER  = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick = 1'b0;
   logic btn_n = 1'b0;
   logic hold_i = 1'b1;
   logic uvlo_i = 1'b0;
   logic ext_ok_i = 1'b0;
   logic pb_stat_o, wake_o, pgood_o, aux_clr_o;
   logic [NR-1:0] rail_en_o;

   int n_chk = 0;
   int n_bad = 0;
   int tcnt = 0;
   bit done_flag = 1'b0;

   always #4 clk = ~clk;

   always @(negedge clk) begin
      if (!rst_n) begin
         tcnt <= 0;
         tick <= 1'b0;
      end else begin
         tcnt <= (tcnt == TPER - 1) ? 0 : tcnt + 1;
         tick <= (tcnt == TPER - 1);
      end
   end

   pbpwr_ctrl #(
      .PRESS_TICKS(PRESS), .HOLD_TICKS(HOLD), .LOCK_TICKS(LOCK),
      .STAGGER_TICKS(STAG), .NUM_RAILS(NR)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .tick_ms(tick), .btn_n(btn_n), .hold_i(hold_i),
      .uvlo_i(uvlo_i), .ext_ok_i(ext_ok_i), .pb_stat_o(pb_stat_o), .wake_o(wake_o),
      .pgood_o(pgood_o), .rail_en_o(rail_en_o), .aux_clr_o(aux_clr_o)
   );

   task automatic chk(string req, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic wait_ticks(int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         while (!tick) @(posedge clk);
      end
      if (n > 0) @(negedge clk);
   endtask

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done_flag) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=hung expected=done");
         finish_run();
      end
   end

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 wake", int'(wake_o), 0);
      chk("R1 rails", int'(rail_en_o), 0);
      chk("R1 pgood", int'(pgood_o), 0);
      chk("R1 pbstat", int'(pb_stat_o), 0);
      chk("R1 clr", int'(aux_clr_o), 0);
      repeat (10) @(negedge clk);
      chk("R1 held-from-reset press", int'(wake_o), 0);

      // R2 release then press powers up
      btn_n = 1'b1;
      @(negedge clk);
      btn_n = 1'b0;
      @(negedge clk);
      chk("R2 wake", int'(wake_o), 1);
      chk("R2 rails", int'(rail_en_o), 1);
      chk("R2 pgood", int'(pgood_o), 0);

      // R3 stagger, R4 entry to on
      wait_ticks(STAG - 1);
      chk("R3 rail0 only", int'(rail_en_o), 1);
      wait_ticks(1);
      chk("R3 rail1", int'(rail_en_o), 3);
      wait_ticks(STAG - 1);
      chk("R3 rail1 hold", int'(rail_en_o), 3);
      wait_ticks(1);
      chk("R3 rail2", int'(rail_en_o), 7);
      chk("R4 pgood not yet", int'(pgood_o), 0);
      @(negedge clk);
      chk("R4 pgood", int'(pgood_o), 1);
      btn_n = 1'b1;
      @(negedge clk);

      // R5 press duration sweep
      for (int d = 1; d <= PRESS + 1; d++) begin
         btn_n = 1'b0;
         wait_ticks(d);
         chk("R5 pbstat after press", int'(pb_stat_o), (d >= PRESS) ? 1 : 0);
         btn_n = 1'b1;
         #1;
         chk("R5 pbstat on release", int'(pb_stat_o), 0);
         @(negedge clk);
      end

      // R6 short hold-low pulses do not shut down
      for (int k = 1; k < HOLD; k++) begin
         hold_i = 1'b0;
         wait_ticks(k);
         hold_i = 1'b1;
         @(negedge clk);
         chk("R6 short hold no shutdown", int'(wake_o), 1);
      end
      hold_i = 1'b0;
      wait_ticks(HOLD);
      chk("R6 still on at limit", int'(wake_o), 1);
      @(negedge clk);
      // R7 entry into power-down
      chk("R7 wake", int'(wake_o), 0);
      chk("R7 rails", int'(rail_en_o), 0);
      chk("R7 pgood", int'(pgood_o), 0);
      chk("R7 clr pulse", int'(aux_clr_o), 1);
      hold_i = 1'b1;
      btn_n = 1'b0;
      ext_ok_i = 1'b1;
      @(negedge clk);
      chk("R7 clr one cycle", int'(aux_clr_o), 0);

      // R9 press held through lockout
      wait_ticks(LOCK);
      repeat (4) @(negedge clk);
      chk("R9 held press ignored", int'(wake_o), 0);
      btn_n = 1'b1;
      @(negedge clk);
      btn_n = 1'b0;
      @(negedge clk);
      chk("R9 fresh press wake", int'(wake_o), 1);
      chk("R9 fresh press rails", int'(rail_en_o), 1);
      wait_ticks(2 * STAG);
      @(negedge clk);
      chk("R4 on again", int'(pgood_o), 1);
      btn_n = 1'b1;

      // R10 undervoltage, R8 lockout length, R11 retry
      uvlo_i = 1'b1;
      @(negedge clk);
      chk("R10 wake", int'(wake_o), 0);
      chk("R10 rails", int'(rail_en_o), 0);
      chk("R10 clr", int'(aux_clr_o), 1);
      uvlo_i = 1'b0;
      hold_i = 1'b0;
      wait_ticks(LOCK - 1);
      chk("R8 in lockout", int'(wake_o), 0);
      wait_ticks(1);
      chk("R8 lockout end", int'(wake_o), 0);
      hold_i = 1'b1;
      @(negedge clk);
      chk("R11 passes off", int'(wake_o), 0);
      @(negedge clk);
      chk("R11 retry wake", int'(wake_o), 1);
      chk("R11 retry rails", int'(rail_en_o), 1);
      wait_ticks(2 * STAG);
      @(negedge clk);
      chk("R4 on after retry", int'(pgood_o), 1);

      // R11 retry waits for external supply
      ext_ok_i = 1'b0;
      uvlo_i = 1'b1;
      @(negedge clk);
      chk("R10 second uv", int'(wake_o), 0);
      uvlo_i = 1'b0;
      wait_ticks(LOCK);
      repeat (6) @(negedge clk);
      chk("R11 waits for supply", int'(wake_o), 0);
      ext_ok_i = 1'b1;
      @(negedge clk);
      chk("R11 supply returns", int'(wake_o), 1);

      done_flag = 1'b1;
      finish_run();
   end
endmodule